// File: doc/BRIEF.md
# Sleep-Mode Entry and Exit Sequencer

This block steers a memory core into and out of a low-power sleep state. A sleep request arrives on an asynchronous, active-high pin that is held low in normal operation. The request is brought into the clock domain through a short flop chain. The sequencer then waits a fixed entry window before it declares sleep. While asleep, it tells the core to disregard every input except the request, and to float its data outputs. The core keeps its stored contents and its internal state during that time.

When the request drops, a fixed wake-up window runs. The core starts sampling its inputs again only when that window has ended. A request that falls before the entry window ends cancels the entry and returns the block straight to the awake state. A wake-up that has started always runs to completion.

A read or write still in flight when sleep begins may be lost. For that reason, the block watches a busy indication from the core. It raises a sticky error flag if sleep is requested while the core is busy.

Top module: `sleep_seq`

## Requirements
- R1: While reset is high, and after reset is released, inputs_ignored, outputs_hiz, asleep and busy_err are all 0.
- R2: With sleep_req held high, asleep, inputs_ignored and outputs_hiz all rise after the fifth rising edge at which sleep_req is sampled high. That count is two synchronizer stages, one decision edge and a two-cycle entry window.
- R3: During the entry window all three status outputs stay 0, so the core keeps accepting inputs.
- R4: After sleep_req is sampled low, asleep falls on the third rising edge. inputs_ignored and outputs_hiz stay high for the two-cycle wake-up window and fall on the fifth edge.
- R5: A high pulse on sleep_req lasting one or two clock cycles cancels the entry, and asleep never rises. A pulse of three cycles or more reaches sleep.
- R6: A started wake-up always completes, even if sleep_req goes high again during it. The block returns to awake (inputs_ignored = 0) and only then begins a new entry.
- R7: busy_err is set at any rising edge where the synchronized request is high, core_busy is 1 and the block is awake or entering sleep. Once set, it stays 1 until reset.
- R8: core_busy has no effect on busy_err while the block is asleep or waking up.
- R9: outputs_hiz always equals inputs_ignored, and asleep = 1 implies inputs_ignored = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| core_busy | input | 1 | Core reports a read or write still pending |
| inputs_ignored | output | 1 | Core must disregard its synchronous inputs |
| outputs_hiz | output | 1 | Core must float its data outputs |
| asleep | output | 1 | Sleep state reached |
| busy_err | output | 1 | Sticky flag: sleep requested while core busy |

## Verification
The bench counts edges exactly across the synchronizer and both windows. A design that is off by one stage would raise or drop asleep a cycle early or late. A design that released the input gate together with asleep would let the core sample inputs during the wake-up window.

Short request pulses of one and two cycles must cancel cleanly, while a three-cycle pulse must reach sleep. A design without the cancel path would enter sleep on a glitch.

A request that returns during wake-up must not keep the gate closed. A design that jumped from wake-up straight back into sleep would never show the brief awake interval.

The error flag is checked in three ways. It must stay set once raised. It must be cleared only by reset. It must not be set by core_busy seen after sleep has begun; a design without that qualification would flag a fault during every sleep period.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_EXIT  = 2'd3
  } slp_state_t;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

  // the last stage takes on the previous value of the stage in front of it
  p_chain_shift_r2: assert property (@(posedge clk) disable iff (rst)
    ##1 (chain[STAGES-1] == $past(chain[(STAGES > 1) ? STAGES-2 : 0]) || STAGES == 1));
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_seq_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_s,
  output slp_state_t state_o,
  output logic       ign_o,
  output logic       hiz_o,
  output logic       asleep_o
);
  localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ENT_LAST = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] EXT_LAST = CW'(EXIT_CYC - 1);

  slp_state_t st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    unique case (st)
      ST_AWAKE: begin
        cnt_nxt = '0;
        if (req_s) st_nxt = ST_ENTER;
      end
      ST_ENTER: begin
        if (!req_s) begin
          st_nxt  = ST_AWAKE;
          cnt_nxt = '0;
        end else if (cnt == ENT_LAST) begin
          st_nxt  = ST_SLEEP;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      ST_SLEEP: begin
        cnt_nxt = '0;
        if (!req_s) st_nxt = ST_EXIT;
      end
      ST_EXIT: begin
        if (cnt == EXT_LAST) begin
          st_nxt  = ST_AWAKE;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      default: begin
        st_nxt  = ST_AWAKE;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_AWAKE;
      cnt      <= '0;
      ign_o    <= 1'b0;
      hiz_o    <= 1'b0;
      asleep_o <= 1'b0;
    end else begin
      st       <= st_nxt;
      cnt      <= cnt_nxt;
      ign_o    <= (st_nxt == ST_SLEEP) || (st_nxt == ST_EXIT);
      hiz_o    <= (st_nxt == ST_SLEEP) || (st_nxt == ST_EXIT);
      asleep_o <= (st_nxt == ST_SLEEP);
    end
  end

  assign state_o = st;

  p_sleep_from_enter_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep_o) |-> $past(st) == ST_ENTER);
  p_enter_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTER) |-> !ign_o && !hiz_o && !asleep_o);
  p_wake_gate_held_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep_o) |-> ign_o);
  p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTER && !req_s) |=> st == ST_AWAKE);
  p_exit_completes_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXIT) |=> (st == ST_EXIT || st == ST_AWAKE));
  p_gate_pair_r9: assert property (@(posedge clk) disable iff (rst)
    (hiz_o == ign_o) && (!asleep_o || ign_o));
endmodule

// File: rtl/sleep_err.sv
module sleep_err
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_s,
  input  logic       busy,
  input  slp_state_t state_i,
  output logic       err_o
);
  logic pre_sleep;
  assign pre_sleep = (state_i == ST_AWAKE) || (state_i == ST_ENTER);

  always_ff @(posedge clk) begin
    if (rst)                           err_o <= 1'b0;
    else if (req_s && busy && pre_sleep) err_o <= 1'b1;
  end

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  p_err_quiet_asleep_r8: assert property (@(posedge clk) disable iff (rst)
    (!err_o && !pre_sleep) |=> !err_o);
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic core_busy,
  output logic inputs_ignored,
  output logic outputs_hiz,
  output logic asleep,
  output logic busy_err
);
  logic       req_s;
  slp_state_t st;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (sleep_req),
    .dout(req_s)
  );

  sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_s   (req_s),
    .state_o (st),
    .ign_o   (inputs_ignored),
    .hiz_o   (outputs_hiz),
    .asleep_o(asleep)
  );

  sleep_err u_err (
    .clk    (clk),
    .rst    (rst),
    .req_s  (req_s),
    .busy   (core_busy),
    .state_i(st),
    .err_o  (busy_err)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> !inputs_ignored && !outputs_hiz && !asleep && !busy_err);
endmodule

// File: tb/tb_sleep_seq.sv
module tb_sleep_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic core_busy = 1'b0;
  logic inputs_ignored, outputs_hiz, asleep, busy_err;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sleep_seq dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .core_busy(core_busy),
    .inputs_ignored(inputs_ignored), .outputs_hiz(outputs_hiz),
    .asleep(asleep), .busy_err(busy_err)
  );

  // {req, busy, exp_ign, exp_hiz, exp_asleep, exp_err}
  localparam int NV = 27;
  localparam logic [5:0] VEC [NV] = '{
    6'b10_0000, 6'b10_0000, 6'b10_0000, 6'b10_0000, 6'b10_1110,
    6'b00_1110, 6'b00_1110, 6'b00_1100, 6'b00_1100, 6'b00_0000,
    6'b10_0000, 6'b10_0000, 6'b00_0000, 6'b00_0000, 6'b00_0000,
    6'b00_0000, 6'b01_0000, 6'b10_0000, 6'b10_0000, 6'b11_0001,
    6'b10_0001, 6'b10_1111, 6'b00_1111, 6'b00_1111, 6'b00_1101,
    6'b00_1101, 6'b00_0001
  };

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got ign/hiz/slp/err=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic b);
    @(negedge clk);
    sleep_req = r;
    core_busy = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sleep_req = 1'b0; core_busy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", {inputs_ignored, outputs_hiz, asleep, busy_err}, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {inputs_ignored, outputs_hiz, asleep, busy_err};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // table covers R2 R3 R4 R5 R7 R9
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4]);
      chk($sformatf("R2/R3/R4/R5/R7/R9 vector %0d", i), outs(), VEC[i][3:0]);
    end
    // R7 sticky across idle
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R7 sticky", outs(), 4'b0001);

    // R1: reset clears the flag
    do_reset();
    step(1'b0, 1'b0);
    chk("R1 after reset", outs(), 4'b0000);

    // R8: busy seen while asleep / waking does not set the flag
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
    chk("R8 asleep", outs(), 4'b1110);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1);
    chk("R8 busy during sleep", outs(), 4'b1110);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1);
    chk("R8 after wake", outs(), 4'b0000);
    step(1'b0, 1'b0);

    // R6: request returns during wake-up
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
    chk("R6 asleep first", outs(), 4'b1110);
    step(1'b0, 1'b0);
    for (int k = 0; k < 2; k++) step(1'b1, 1'b0);
    chk("R6 waking", outs(), 4'b1100);
    for (int k = 0; k < 2; k++) step(1'b1, 1'b0);
    chk("R6 awake interval", outs(), 4'b0000);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
    chk("R6 re-entered", outs(), 4'b1110);
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0);
    chk("R6 final wake", outs(), 4'b0000);

    // R5: three-cycle pulse reaches sleep
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R5 3-cycle not yet", outs(), 4'b0000);
    step(1'b0, 1'b0);
    chk("R5 3-cycle sleeps", outs(), 4'b1110);
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0);
    chk("R4 woke again", outs(), 4'b0000);

    // R5: one-cycle glitch
    step(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b0);
      chk($sformatf("R5 glitch edge %0d", k), outs(), 4'b0000);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule